// File: doc/BRIEF.md
# Serial Receiver Status Flags

This block keeps the status flags of a serial receiver that runs in a synchronous 8-bit mode or in one of three asynchronous modes. The receive shifter gives it a one-cycle `word_done` strobe for each finished word. With that strobe come three qualifiers: a bad parity bit, a missing stop bit and the ninth (address/data) bit. From these the block decides in the same cycle whether the word may enter the receive data register. It then updates the parity error, framing error, overrun, data-full and received-bit-8 flags.

Software clears the error flags with a two-step access: a status read while an error is showing, then a data read. A control write or any reset between the two steps cancels the sequence. A data read on its own only empties the data register. A pending framing error closes the load gate until the two-step clear has been done. So a data read alone cannot reopen the receive path after a framing error.

Top module: `rx_status_flags`

## Requirements
- R1: The main reset `rst` and each line of `extra_rst` clear every flag at the next clock edge. They also cancel any armed clear sequence.
- R2: When `word_done` is high while both `rdf` and `frm_err` are low, `load_en` is high in that same cycle and `rdf` is 1 after the edge.
- R3: `par_err` can be set only in mode 2 (asynchronous with parity). It is set when an accepted word has `par_bad` high. In modes 0, 1 and 3 it stays 0.
- R4: `frm_err` is set at the same edge that sets `rdf`, when an accepted word in modes 1, 2 or 3 has `stop_miss` high. In mode 0 (8-bit synchronous) it stays 0.
- R5: While `frm_err` is 1, `load_en` stays low and no word is accepted, even after `rdf` has been emptied.
- R6: A `word_done` while `rdf` or `frm_err` is 1 leaves `load_en` low and sets `ovr_err` at the next edge. The refused word's parity, stop and bit-8 qualifiers change no flag, so overrun is the only error it reports.
- R7: A `rd_status` while any of `par_err`, `frm_err` or `ovr_err` is 1 arms the clear. The next `rd_data` in a later cycle clears all three error flags. A `rd_data` with no armed sequence leaves the error flags unchanged.
- R8: A `ctl_wr` after the arming status read and before the data read cancels the sequence, so the following `rd_data` leaves the error flags set.
- R9: In mode 3 (11-bit multidrop) an accepted word copies `bit8_in` into `rx_bit8`. Reads, refused words and words accepted in other modes leave `rx_bit8` unchanged.
- R10: `rd_data` clears `rdf` at the next edge, whether or not a clear sequence is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Main synchronous reset, active high |
| extra_rst | input | N_EXTRA | Other synchronous reset sources (software, block, stop), active high |
| mode | input | 2 | 0 sync 8-bit, 1 async no parity, 2 async with parity, 3 async 11-bit multidrop |
| word_done | input | 1 | One-cycle strobe: the shifter has finished a word |
| par_bad | input | 1 | Parity of the finished word is wrong |
| stop_miss | input | 1 | Stop bit of the finished word was not found |
| bit8_in | input | 1 | Ninth bit of the finished word (address marker) |
| rd_status | input | 1 | Status register read strobe |
| rd_data | input | 1 | Receive data register read strobe |
| ctl_wr | input | 1 | Control register write strobe |
| par_err | output | 1 | Parity error flag |
| frm_err | output | 1 | Framing error flag |
| ovr_err | output | 1 | Overrun flag |
| rdf | output | 1 | Receive data register full |
| rx_bit8 | output | 1 | Captured ninth bit |
| load_en | output | 1 | Permission to load the finished word into the receive data register |

## Verification
The bench sweeps every mode against every combination of parity, stop and ninth-bit qualifiers. For each combination it checks which flags can be set. A design that ignored the mode would show parity errors in modes without parity, or framing errors in synchronous mode. Each combination is followed by a second word that arrives while the register is still full. That word checks that overrun masks the word's own errors and leaves the ninth bit untouched. A design with the wrong priority would raise parity or framing errors for a word it threw away. The bench also empties the register without a status read while a framing error is pending. A design that reopened the gate there would accept a word it should refuse. Finally, a control write between the status read and the data read must leave the errors in place, or the design is clearing on an incomplete sequence.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        MODE_SYNC8       = 2'd0,
        MODE_ASYNC_NOPAR = 2'd1,
        MODE_ASYNC_PAR   = 2'd2,
        MODE_MDROP       = 2'd3
    } rx_mode_e;

    typedef struct packed {
        logic par_bad;
        logic stop_miss;
        logic bit8;
    } frame_info_t;

    typedef struct packed {
        logic pe;
        logic fe;
        logic ovr;
        logic rdf;
        logic bit8;
    } flags_t;

    function automatic logic mode_has_parity(rx_mode_e m);
        return m == MODE_ASYNC_PAR;
    endfunction

    function automatic logic mode_is_async(rx_mode_e m);
        return m != MODE_SYNC8;
    endfunction

    function automatic logic mode_keeps_bit8(rx_mode_e m);
        return m == MODE_MDROP;
    endfunction

    function automatic logic any_error(flags_t f);
        return f.pe | f.fe | f.ovr;
    endfunction

endpackage

// File: rtl/rxf_load_gate.sv
module rxf_load_gate
    import rxf_pkg::*;
(
    input  logic   clk,
    input  logic   any_rst,
    input  logic   word_done,
    input  flags_t cur,
    output logic   load_en,
    output logic   ovr_evt
);

    logic blocked;

    always_comb begin
        blocked = cur.rdf | cur.fe;
        load_en = word_done & ~blocked;
        ovr_evt = word_done & blocked;
    end

    // A pending framing error keeps the gate shut
    p_fe_blocks_r5: assert property (@(posedge clk) disable iff (any_rst)
        cur.fe |-> !load_en);

    p_load_excl_r6: assert property (@(posedge clk) disable iff (any_rst)
        !(load_en && ovr_evt));

endmodule

// File: rtl/rxf_clear_seq.sv
module rxf_clear_seq (
    input  logic clk,
    input  logic any_rst,
    input  logic rd_status,
    input  logic rd_data,
    input  logic ctl_wr,
    input  logic err_present,
    output logic clr_err
);

    logic armed_q;
    logic armed_d;

    always_comb begin
        clr_err = rd_data & armed_q & ~ctl_wr & ~any_rst;
        armed_d = armed_q;
        if (clr_err) begin
            armed_d = 1'b0;
        end else if (rd_status && err_present) begin
            armed_d = 1'b1;
        end
        if (ctl_wr) begin
            armed_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (any_rst) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= armed_d;
        end
    end

    p_arm_r7: assert property (@(posedge clk) disable iff (any_rst)
        (rd_status && err_present && !ctl_wr && !(rd_data && armed_q)) |=> armed_q);

    p_wr_disarms_r8: assert property (@(posedge clk) disable iff (any_rst)
        ctl_wr |=> !armed_q);

endmodule

// File: rtl/rxf_flag_regs.sv
module rxf_flag_regs
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        any_rst,
    input  rx_mode_e    mode,
    input  logic        load_en,
    input  logic        ovr_evt,
    input  frame_info_t info,
    input  logic        clr_err,
    input  logic        rd_data,
    output flags_t      flags
);

    flags_t q;
    flags_t d;

    always_comb begin
        d = q;
        if (rd_data) begin
            d.rdf = 1'b0;
        end
        if (clr_err) begin
            d.pe  = 1'b0;
            d.fe  = 1'b0;
            d.ovr = 1'b0;
        end
        if (load_en) begin
            d.rdf = 1'b1;
            d.pe  = mode_has_parity(mode) & info.par_bad;
            d.fe  = mode_is_async(mode) & info.stop_miss;
            if (mode_keeps_bit8(mode)) begin
                d.bit8 = info.bit8;
            end
        end
        if (ovr_evt) begin
            d.ovr = 1'b1;
        end
        if (!mode_has_parity(mode)) begin
            d.pe = 1'b0;
        end
        if (!mode_is_async(mode)) begin
            d.fe = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (any_rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign flags = q;

    p_fe_with_rdf_r4: assert property (@(posedge clk) disable iff (any_rst)
        $rose(q.fe) |-> $rose(q.rdf));

    p_ovr_set_r6: assert property (@(posedge clk) disable iff (any_rst)
        ovr_evt |=> q.ovr);

    p_bit8_hold_r9: assert property (@(posedge clk) disable iff (any_rst)
        !load_en |=> $stable(q.bit8));

    p_rdf_empty_r10: assert property (@(posedge clk) disable iff (any_rst)
        (rd_data && !load_en) |=> !q.rdf);

endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags
    import rxf_pkg::*;
#(
    parameter int N_EXTRA = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_EXTRA-1:0] extra_rst,
    input  logic [1:0]         mode,
    input  logic               word_done,
    input  logic               par_bad,
    input  logic               stop_miss,
    input  logic               bit8_in,
    input  logic               rd_status,
    input  logic               rd_data,
    input  logic               ctl_wr,
    output logic               par_err,
    output logic               frm_err,
    output logic               ovr_err,
    output logic               rdf,
    output logic               rx_bit8,
    output logic               load_en
);

    logic        any_rst;
    rx_mode_e    mode_e;
    frame_info_t info;
    flags_t      flags;
    logic        ovr_evt;
    logic        clr_err;

    always_comb begin
        any_rst = rst | (|extra_rst);
        mode_e  = rx_mode_e'(mode);
        info    = '{par_bad: par_bad, stop_miss: stop_miss, bit8: bit8_in};
    end

    rxf_load_gate u_gate (
        .clk       (clk),
        .any_rst   (any_rst),
        .word_done (word_done),
        .cur       (flags),
        .load_en   (load_en),
        .ovr_evt   (ovr_evt)
    );

    rxf_clear_seq u_clr (
        .clk         (clk),
        .any_rst     (any_rst),
        .rd_status   (rd_status),
        .rd_data     (rd_data),
        .ctl_wr      (ctl_wr),
        .err_present (any_error(flags)),
        .clr_err     (clr_err)
    );

    rxf_flag_regs u_regs (
        .clk     (clk),
        .any_rst (any_rst),
        .mode    (mode_e),
        .load_en (load_en),
        .ovr_evt (ovr_evt),
        .info    (info),
        .clr_err (clr_err),
        .rd_data (rd_data),
        .flags   (flags)
    );

    assign par_err = flags.pe;
    assign frm_err = flags.fe;
    assign ovr_err = flags.ovr;
    assign rdf     = flags.rdf;
    assign rx_bit8 = flags.bit8;

    p_reset_r1: assert property (@(posedge clk)
        any_rst |=> (!par_err && !frm_err && !ovr_err && !rdf && !rx_bit8));

endmodule

// File: tb/test_rx_status_flags.sv
module test_rx_status_flags;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] extra_rst;
    logic [1:0] mode;
    logic       word_done, par_bad, stop_miss, bit8_in;
    logic       rd_status, rd_data, ctl_wr;
    logic       par_err, frm_err, ovr_err, rdf, rx_bit8, load_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    rx_status_flags #(.N_EXTRA(3)) i_rx_status_flags (
        .clk(clk), .rst(rst), .extra_rst(extra_rst), .mode(mode),
        .word_done(word_done), .par_bad(par_bad), .stop_miss(stop_miss),
        .bit8_in(bit8_in), .rd_status(rd_status), .rd_data(rd_data),
        .ctl_wr(ctl_wr), .par_err(par_err), .frm_err(frm_err),
        .ovr_err(ovr_err), .rdf(rdf), .rx_bit8(rx_bit8), .load_en(load_en)
    );

    task automatic tick();
        @(posedge clk);
        #1;
        rst = 0; extra_rst = '0; word_done = 0;
        rd_status = 0; rd_data = 0; ctl_wr = 0;
    endtask

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] flg();
        return {par_err, frm_err, ovr_err, rdf, rx_bit8};
    endfunction

    task automatic word(input logic pb, input logic sm, input logic b8);
        word_done = 1; par_bad = pb; stop_miss = sm; bit8_in = b8;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; extra_rst = '0; mode = 2'd0;
        word_done = 0; par_bad = 0; stop_miss = 0; bit8_in = 0;
        rd_status = 0; rd_data = 0; ctl_wr = 0;
        tick();
        chk("R1 reset state", flg(), 5'b00000);

        // Sweep: every mode against every qualifier combination
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 8; v++) begin
                logic pb, sm, b8, e_pe, e_fe, e_b8;
                pb = v[0]; sm = v[1]; b8 = v[2];
                e_pe = (m == 2) && pb;
                e_fe = (m != 0) && sm;
                e_b8 = (m == 3) && b8;
                rst = 1; tick();
                chk("R1 sweep reset", flg(), 5'b00000);
                mode = m[1:0];
                word(pb, sm, b8); #1;
                chk("R2 load_en", {4'b0, load_en}, 5'b00001);
                tick();
                chk("R2 R3 R4 R9 accepted word", flg(), {e_pe, e_fe, 1'b0, 1'b1, e_b8});
                word(~pb, ~sm, ~b8); #1;
                chk("R6 gate shut", {4'b0, load_en}, 5'b00000);
                tick();
                chk("R6 overrun only", flg(), {e_pe, e_fe, 1'b1, 1'b1, e_b8});
                rd_data = 1; tick();
                chk("R10 R7 unarmed data read", flg(), {e_pe, e_fe, 1'b1, 1'b0, e_b8});
                if (e_fe) begin
                    word(1'b0, 1'b0, ~b8); #1;
                    chk("R5 gate shut by framing", {4'b0, load_en}, 5'b00000);
                    tick();
                    chk("R5 word refused", flg(), {e_pe, e_fe, 1'b1, 1'b0, e_b8});
                end
                rd_status = 1; tick();
                chk("R9 status read keeps flags", flg(), {e_pe, e_fe, 1'b1, 1'b0, e_b8});
                rd_data = 1; tick();
                chk("R7 R9 sequence clear", flg(), {4'b0000, e_b8});
                word(1'b0, 1'b0, b8); #1;
                chk("R5 gate reopened", {4'b0, load_en}, 5'b00001);
                tick();
            end
        end

        // R8: control write between status read and data read
        rst = 1; tick();
        mode = 2'd2;
        word(1'b1, 1'b0, 1'b0); tick();
        rd_status = 1; tick();
        ctl_wr = 1; tick();
        rd_data = 1; tick();
        chk("R8 write cancels clear", flg(), 5'b10000);
        rd_status = 1; tick();
        rd_data = 1; tick();
        chk("R7 rearmed clear", flg(), 5'b00000);

        // R9: word accepted outside multidrop keeps bit 8
        rst = 1; tick();
        mode = 2'd3;
        word(1'b0, 1'b0, 1'b1); tick();
        rd_data = 1; tick();
        mode = 2'd1;
        word(1'b0, 1'b0, 1'b0); tick();
        chk("R9 other mode keeps bit8", flg(), 5'b00011);

        // R1: each extra reset source clears flags and the armed sequence
        for (int i = 0; i < 3; i++) begin
            rst = 1; tick();
            mode = 2'd3;
            word(1'b1, 1'b1, 1'b1); tick();
            word(1'b0, 1'b0, 1'b0); tick();
            rd_status = 1; tick();
            extra_rst[i] = 1'b1; tick();
            chk("R1 extra reset", flg(), 5'b00000);
            mode = 2'd2;
            word(1'b1, 1'b0, 1'b0); tick();
            rd_data = 1; tick();
            chk("R1 sequence cancelled by reset", flg(), 5'b10000);
        end

        // R3/R4 in 8-bit sync mode with both qualifiers bad
        rst = 1; tick();
        mode = 2'd0;
        word(1'b1, 1'b1, 1'b1); tick();
        chk("R3 R4 sync mode no errors", flg(), 5'b00010);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule